// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

The block arbitrates twelve interrupt sources for a small 8-bit processor core. It keeps one pending flag per source. A flag is set by a one-cycle pulse from the owning peripheral and cleared by a software strobe. Each source also has a programmable enable bit and a programmable priority bit, and one global enable gates every source. Among the pending, enabled sources, the controller picks a winner by level first and then by a fixed index order. It raises a registered request to the core and presents the winner's fixed vector address. The request and the vector stay fixed until the core acknowledges.

On the acknowledge, the controller records the winner's level as in service. For the four lowest-numbered sources (two external pins and two timers), it also clears the flag in hardware. Every other flag stays set until software clears it. A routine in service at the low level can be preempted only by a high-level source. A routine in service at the high level cannot be preempted at all. A return strobe releases the most recently entered level. Reset is the implicit top-priority event: it cannot be masked, and it leaves the vector output at address zero.

Top module: `irq_ctrl`

## Requirements
- R1: While and after reset, irq_req_o is 0, irq_vec_o is 16'h0000, and all flags, enables, priorities and the global enable are 0.
- R2: A bit of set_i pulsed in one cycle makes flag_o of that source 1 after the next clock edge. A bit of sw_clr_i clears the flag at that edge. If set and clear arrive in the same cycle, the set wins.
- R3: A write with reg_sel_i = 0 loads enables of sources 0..5 from data bits 5:0 and the global enable from bit 7. A write with reg_sel_i = 1 loads enables of sources 6..11 from bits 5:0. Selects 2 and 3 load the priority bits in the same layout, and a priority bit of 1 means high level.
- R4: While the global enable is 0, no request is raised, whatever the flags and enables.
- R5: The vector of source n is 16'h0003 + 8*n, from 16'h0003 for source 0 to 16'h005B for source 11.
- R6: A pending enabled high-level source beats any low-level source. Within one level, the lowest source index wins.
- R7: irq_req_o rises at the clock edge after the winner's flag becomes visible. Request and vector then hold until irq_ack_i, and the request is 0 in the cycle after the acknowledge.
- R8: The acknowledge clears the flag of the winning source if it is source 0..3, unless that source is set again in the same cycle.
- R9: Flags of sources 4..11 are not changed by the acknowledge and stay set until sw_clr_i clears them.
- R10: While a low-level routine is in service, only a high-level source can raise a request. While a high-level routine is in service, no request is raised.
- R11: A pulse on reti_i releases the high level if it is in service, and otherwise releases the low level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| set_i | input | 12 | Per-source flag set pulses from peripherals |
| sw_clr_i | input | 12 | Per-source flag clear strobes from software |
| reg_we_i | input | 1 | Configuration write strobe |
| reg_sel_i | input | 2 | Register select: 0/1 enable banks, 2/3 priority banks |
| reg_wdata_i | input | 8 | Configuration write data |
| irq_ack_i | input | 1 | Core accepts the pending request |
| reti_i | input | 1 | Return from the current service routine |
| flag_o | output | 12 | Current pending flags |
| irq_req_o | output | 1 | Interrupt request to the core |
| irq_vec_o | output | 16 | Vector address of the requested source |

## Verification
On every cycle, the assertions check the following. The request and its vector hold until the acknowledge, and the request drops right after it. Every vector lies on the 8-byte grid. A request never rises while the global enable is off, or over a high-level routine. A low-level request needs an idle in-service state. Software-cleared flags never vanish without a clear strobe, and the four hardware-cleared flags do drop on the acknowledge. Only the bench's scenarios show which source actually wins when several are pending at mixed levels, the exact vector of each source, and the order in which sources are served as returns unwind nested levels.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int unsigned VEC_W = 16;

  typedef enum logic {
    LVL_LO = 1'b0,
    LVL_HI = 1'b1
  } irq_lvl_e;

  function automatic logic [VEC_W-1:0] irq_vector(input int unsigned idx,
                                                   input int unsigned base,
                                                   input int unsigned step);
    return VEC_W'(base + step * idx);
  endfunction
endpackage

// File: rtl/irq_flags.sv
module irq_flags #(
  parameter int unsigned NSRC   = 12,
  parameter int unsigned NHWCLR = 4,
  parameter int unsigned IDX_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NSRC-1:0]  set_i,
  input  logic [NSRC-1:0]  sw_clr_i,
  input  logic             hw_clr_i,
  input  logic [IDX_W-1:0] hw_idx_i,
  output logic [NSRC-1:0]  flag_o
);
  logic [NSRC-1:0] flag_q, hw_clr;

  for (genvar i = 0; i < NSRC; i++) begin : g_hw
    if (i < NHWCLR) begin : g_auto
      assign hw_clr[i] = hw_clr_i && (hw_idx_i == IDX_W'(i));
    end else begin : g_soft
      assign hw_clr[i] = 1'b0;
    end
  end

  // new events win over clears in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_q & ~sw_clr_i & ~hw_clr) | set_i;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/irq_arb.sv
module irq_arb
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned NSRC  = 12,
  parameter int unsigned IDX_W = 4
) (
  input  logic [NSRC-1:0]  flag_i,
  input  logic [NSRC-1:0]  en_i,
  input  logic [NSRC-1:0]  pr_i,
  input  logic             gen_i,
  input  logic [1:0]       in_svc_i,   // [1] high level busy, [0] low level busy
  output logic             vld_o,
  output logic [IDX_W-1:0] idx_o,
  output irq_lvl_e         lvl_o
);
  logic [NSRC-1:0] cand, hi, lo;

  function automatic logic [IDX_W-1:0] first_set(input logic [NSRC-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NSRC - 1; i >= 0; i--) if (v[i]) r = IDX_W'(i);
    return r;
  endfunction

  assign cand = gen_i ? (flag_i & en_i) : '0;
  assign hi   = cand & pr_i;
  assign lo   = cand & ~pr_i;

  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    lvl_o = LVL_LO;
    if (|hi && !in_svc_i[1]) begin
      vld_o = 1'b1;
      idx_o = first_set(hi);
      lvl_o = LVL_HI;
    end else if (|lo && in_svc_i == 2'b00) begin
      vld_o = 1'b1;
      idx_o = first_set(lo);
    end
  end
endmodule

// File: rtl/irq_svc.sv
module irq_svc
  import irq_ctrl_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     push_i,
  input  irq_lvl_e push_lvl_i,
  input  logic     pop_i,
  output logic [1:0] in_svc_o
);
  logic hi_q, lo_q, hi_d, lo_d;

  always_comb begin
    hi_d = hi_q;
    lo_d = lo_q;
    if (pop_i) begin
      if (hi_q) hi_d = 1'b0;
      else      lo_d = 1'b0;
    end
    if (push_i) begin
      if (push_lvl_i == LVL_HI) hi_d = 1'b1;
      else                      lo_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= 1'b0;
      lo_q <= 1'b0;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign in_svc_o = {hi_q, lo_q};
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned BANK_W   = 6,
  parameter int unsigned NHWCLR   = 4,
  parameter int unsigned VEC_BASE = 3,
  parameter int unsigned VEC_STEP = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [2*BANK_W-1:0]    set_i,
  input  logic [2*BANK_W-1:0]    sw_clr_i,
  input  logic                   reg_we_i,
  input  logic [1:0]             reg_sel_i,
  input  logic [7:0]             reg_wdata_i,
  input  logic                   irq_ack_i,
  input  logic                   reti_i,
  output logic [2*BANK_W-1:0]    flag_o,
  output logic                   irq_req_o,
  output logic [VEC_W-1:0]       irq_vec_o
);
  localparam int unsigned NSRC  = 2 * BANK_W;
  localparam int unsigned IDX_W = $clog2(NSRC);

  logic [NSRC-1:0]  en_q, pr_q;
  logic             gen_q;
  logic             req_q;
  logic [IDX_W-1:0] req_idx;
  irq_lvl_e         req_lvl;
  logic [VEC_W-1:0] vec_q;
  logic             arb_vld;
  logic [IDX_W-1:0] arb_idx;
  irq_lvl_e         arb_lvl;
  logic [1:0]       in_svc;
  logic             take;

  assign take = req_q && irq_ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      pr_q  <= '0;
      gen_q <= 1'b0;
    end else if (reg_we_i) begin
      case (reg_sel_i)
        2'd0: begin
          en_q[BANK_W-1:0] <= reg_wdata_i[BANK_W-1:0];
          gen_q            <= reg_wdata_i[7];
        end
        2'd1: en_q[NSRC-1:BANK_W] <= reg_wdata_i[BANK_W-1:0];
        2'd2: pr_q[BANK_W-1:0]    <= reg_wdata_i[BANK_W-1:0];
        default: pr_q[NSRC-1:BANK_W] <= reg_wdata_i[BANK_W-1:0];
      endcase
    end
  end

  irq_flags #(.NSRC(NSRC), .NHWCLR(NHWCLR), .IDX_W(IDX_W)) i_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set_i),
    .sw_clr_i (sw_clr_i),
    .hw_clr_i (take),
    .hw_idx_i (req_idx),
    .flag_o   (flag_o)
  );

  irq_arb #(.NSRC(NSRC), .IDX_W(IDX_W)) i_arb (
    .flag_i   (flag_o),
    .en_i     (en_q),
    .pr_i     (pr_q),
    .gen_i    (gen_q),
    .in_svc_i (in_svc),
    .vld_o    (arb_vld),
    .idx_o    (arb_idx),
    .lvl_o    (arb_lvl)
  );

  irq_svc i_svc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (take),
    .push_lvl_i (req_lvl),
    .pop_i      (reti_i),
    .in_svc_o   (in_svc)
  );

  // request latch: once raised, held unchanged until the core takes it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      req_idx <= '0;
      req_lvl <= LVL_LO;
      vec_q   <= '0;
    end else if (take) begin
      req_q <= 1'b0;
    end else if (!req_q && arb_vld) begin
      req_q   <= 1'b1;
      req_idx <= arb_idx;
      req_lvl <= arb_lvl;
      vec_q   <= irq_vector(int'(arb_idx), VEC_BASE, VEC_STEP);
    end
  end

  assign irq_req_o = req_q;
  assign irq_vec_o = vec_q;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int unsigned NSRC     = 12,
  parameter int unsigned NHWCLR   = 4,
  parameter int unsigned IDX_W    = 4,
  parameter int unsigned VEC_W    = 16,
  parameter int unsigned VEC_BASE = 3,
  parameter int unsigned VEC_STEP = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NSRC-1:0]  set_i,
  input logic [NSRC-1:0]  sw_clr_i,
  input logic             irq_ack_i,
  input logic [NSRC-1:0]  flag_o,
  input logic             irq_req_o,
  input logic [VEC_W-1:0] irq_vec_o,
  input logic             gen_q,
  input logic [1:0]       in_svc,
  input logic [IDX_W-1:0] req_idx,
  input logic             req_lvl
);
  localparam logic [NSRC-1:0]  SWM     = {NSRC{1'b1}} << NHWCLR;
  localparam logic [VEC_W-1:0] VEC_MAX = VEC_W'(VEC_BASE + VEC_STEP * (NSRC - 1));
  localparam logic [2:0]       VEC_LSB = 3'(VEC_BASE);

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o && !irq_ack_i |=> irq_req_o && $stable(irq_vec_o));

  p_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o && irq_ack_i |=> !irq_req_o);

  p_vec_grid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> irq_vec_o[2:0] == VEC_LSB && irq_vec_o <= VEC_MAX);

  p_gen_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_req_o) |-> $past(gen_q));

  p_hi_block_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_req_o) |-> !$past(in_svc[1]));

  p_lo_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_req_o) && !req_lvl |-> $past(in_svc) == 2'b00);

  p_hw_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o && irq_ack_i && (int'(req_idx) < NHWCLR) && !set_i[req_idx]
      |=> !flag_o[$past(req_idx)]);

  p_soft_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flag_o & $past(flag_o & ~sw_clr_i)) & SWM) == ($past(flag_o & ~sw_clr_i) & SWM));
endmodule

bind irq_ctrl irq_ctrl_chk #(
  .NSRC(NSRC), .NHWCLR(NHWCLR), .IDX_W(IDX_W), .VEC_W(irq_ctrl_pkg::VEC_W),
  .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .set_i     (set_i),
  .sw_clr_i  (sw_clr_i),
  .irq_ack_i (irq_ack_i),
  .flag_o    (flag_o),
  .irq_req_o (irq_req_o),
  .irq_vec_o (irq_vec_o),
  .gen_q     (gen_q),
  .in_svc    (in_svc),
  .req_idx   (req_idx),
  .req_lvl   (req_lvl)
);

// File: tb/test_irq_ctrl.sv
module test_irq_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] set_i = '0, sw_clr_i = '0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_sel_i = '0;
  logic [7:0]  reg_wdata_i = '0;
  logic        irq_ack_i = 1'b0, reti_i = 1'b0;
  logic [11:0] flag_o;
  logic        irq_req_o;
  logic [15:0] irq_vec_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  irq_ctrl i_irq_ctrl (.*);

  function automatic int vec_of(input int n);
    return 3 + 8 * n;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    reg_we_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d;
    tick();
    reg_we_i = 1'b0;
  endtask

  task automatic set_src(input logic [11:0] m);
    set_i = m; tick(); set_i = '0;
  endtask

  task automatic sw_clear(input logic [11:0] m);
    sw_clr_i = m; tick(); sw_clr_i = '0;
  endtask

  task automatic ack();
    irq_ack_i = 1'b1; tick(); irq_ack_i = 1'b0;
  endtask

  task automatic ret();
    reti_i = 1'b1; tick(); reti_i = 1'b0;
  endtask

  task automatic expect_req(input int v, input string req);
    chk(irq_req_o === 1'b1, req, irq_req_o, 1);
    chk(irq_vec_o === 16'(v), req, irq_vec_o, v);
  endtask

  task automatic expect_idle(input string req);
    chk(irq_req_o === 1'b0, req, irq_req_o, 0);
  endtask

  task automatic t_reset();
    chk(irq_req_o === 1'b0, "R1", irq_req_o, 0);
    chk(irq_vec_o === 16'h0000, "R1", irq_vec_o, 0);
    chk(flag_o === 12'h000, "R1", flag_o, 0);
    rst_ni = 1'b1;
    tick();
    // nothing enabled: a flag alone raises no request (R1 enables are clear)
    set_src(12'h001); tick();
    expect_idle("R1");
    sw_clear(12'h001);
    chk(flag_o === 12'h000, "R2", flag_o, 0);
  endtask

  task automatic t_global();
    wr(2'd0, 8'h04);
    set_src(12'h004); tick(); tick();
    expect_idle("R4");
    wr(2'd0, 8'h84);
    tick();
    expect_req(vec_of(2), "R4");
    wr(2'd0, 8'h04); tick();
    expect_req(vec_of(2), "R7");
    ack();
    expect_idle("R7");
    chk(flag_o[2] === 1'b0, "R8", flag_o[2], 0);
    ret();
  endtask

  task automatic t_vectors();
    wr(2'd2, 8'h00); wr(2'd3, 8'h00);
    for (int n = 0; n < 12; n++) begin
      if (n < 6) begin wr(2'd0, 8'h80 | 8'(1 << n)); wr(2'd1, 8'h00); end
      else       begin wr(2'd0, 8'h80); wr(2'd1, 8'(1 << (n - 6))); end
      set_src(12'(1 << n));
      expect_idle("R7");
      tick();
      expect_req(vec_of(n), "R5");
      ack();
      expect_idle("R7");
      if (n < 4) chk(flag_o[n] === 1'b0, "R8", flag_o[n], 0);
      else       chk(flag_o[n] === 1'b1, "R9", flag_o[n], 1);
      tick();
      expect_idle("R10");
      sw_clear(12'(1 << n));
      ret();
      tick();
      expect_idle("R11");
    end
  endtask

  task automatic t_ties();
    wr(2'd0, 8'h88); wr(2'd1, 8'h12); wr(2'd2, 8'h00); wr(2'd3, 8'h00);
    set_src(12'h488);                    // sources 3, 7, 10 at low level
    tick();
    expect_req(vec_of(3), "R6");
    ack();
    chk(flag_o === 12'h480, "R8", flag_o, 12'h480);
    ret(); tick();
    expect_req(vec_of(7), "R6");
    ack(); sw_clear(12'h080); ret(); tick();
    expect_req(vec_of(10), "R6");
    ack(); sw_clear(12'h400); ret();
    // source 10 high, source 1 low, pending together
    wr(2'd3, 8'h10); wr(2'd0, 8'h82);
    set_src(12'h402);
    tick();
    expect_req(vec_of(10), "R6");
    ack(); tick();
    expect_idle("R10");
    sw_clear(12'h400); ret(); tick();
    expect_req(vec_of(1), "R11");
    ack();
    chk(flag_o[1] === 1'b0, "R8", flag_o[1], 0);
    ret();
  endtask

  task automatic t_preempt();
    wr(2'd0, 8'hA1); wr(2'd1, 8'h05); wr(2'd2, 8'h00); wr(2'd3, 8'h05);
    set_src(12'h020); tick();
    expect_req(vec_of(5), "R5");
    ack();
    set_src(12'h001); tick(); tick();
    expect_idle("R10");
    set_src(12'h100); tick();
    expect_req(vec_of(8), "R10");
    ack();
    set_src(12'h040); tick(); tick();
    expect_idle("R10");
    sw_clear(12'h100);
    ret(); tick();                       // high popped, low still busy
    expect_req(vec_of(6), "R11");
    ack(); sw_clear(12'h040); ret(); tick();
    expect_idle("R11");
    sw_clear(12'h020); ret(); tick();
    expect_req(vec_of(0), "R11");
    ack();
    chk(flag_o === 12'h000, "R8", flag_o, 0);
    ret();
  endtask

  task automatic t_persist();
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    set_src(12'h200);
    repeat (5) tick();
    chk(flag_o[9] === 1'b1, "R9", flag_o[9], 1);
    set_i = 12'h200; sw_clr_i = 12'h200; tick(); set_i = '0; sw_clr_i = '0;
    chk(flag_o[9] === 1'b1, "R2", flag_o[9], 1);
    sw_clear(12'h200);
    chk(flag_o[9] === 1'b0, "R2", flag_o[9], 0);
    // priority bank write lands on bits 5:0 of select 3 (R3)
    wr(2'd1, 8'h01); wr(2'd0, 8'h90); wr(2'd3, 8'h01);
    set_src(12'h050); tick();
    expect_req(vec_of(6), "R3");
    ack(); sw_clear(12'h040); ret(); tick();
    expect_req(vec_of(4), "R3");
    ack(); sw_clear(12'h010); ret();
  endtask

  initial begin
    tick(); tick();
    t_reset();
    t_global();
    t_vectors();
    t_ties();
    t_preempt();
    t_persist();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule